// File: doc/BRIEF.md
# SDRAM Read Burst Output Control

This block models the output side of one SDRAM bank while it is being read. It samples three command strobes: a read, a precharge aimed at this bank, and a precharge of all banks. It also takes a CAS latency select and a burst length code. From these it produces a data-valid flag and a beat index. Together these two outputs say, cycle by cycle, which beat of the burst the bank drives on the data bus. When neither is active, the bus is in its high-impedance state.

A precharge does not stop the output at once. It closes the bus a fixed number of clocks later, equal to the CAS latency. Any beats still due after that point are dropped. The block raises a one-cycle flag in the earliest cycle in which a precharge can be accepted without losing the end of the burst. A controller can use this flag to close the row as early as possible.

A read that arrives while a burst is still running starts a new burst. Beats of the old burst keep coming until the first beat of the new one is due.

Top module: `sdr_rd_burst_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `dq_valid`, `beat_idx` and `pre_ok` are all zero.
- R2: With `rd_cmd` high in cycle c, beat k of the burst is driven in cycle c+CL+k: `dq_valid`=1 and `beat_idx`=k. CL is 2 when `cas_sel`=0 and 3 when `cas_sel`=1.
- R3: The `blen_code` sampled with the read sets the burst length: code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8.
- R4: In any cycle in which no beat is driven, `dq_valid` is 0 and `beat_idx` is 0.
- R5: A precharge accepted in cycle p means no beat is driven in cycle p+CL or later, until a later read's burst begins. Beats due before cycle p+CL are delivered unchanged.
- R6: `pall_cmd` has exactly the same effect on this bank as `pre_cmd`.
- R7: A precharge strobe in the same cycle as `rd_cmd` is ignored.
- R8: After a read in cycle c with burst length BL, `pre_ok` is high for exactly the one cycle c+BL. This equals the last beat cycle minus (CL−1).
- R9: A precharge issued in the `pre_ok` cycle still delivers every beat. A precharge issued one cycle earlier loses exactly the last beat.
- R10: A read in cycle r during a burst lets the old burst continue only up to cycle r+CL−1. The new burst then starts in cycle r+CL at index 0.
- R11: An accepted precharge cancels a pending `pre_ok` pulse. A new read replaces the pending pulse with its own.
- R12: A precharge with no burst in flight leaves all outputs idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read command strobe for this bank |
| pre_cmd | input | 1 | Precharge strobe for this bank |
| pall_cmd | input | 1 | Precharge-all strobe |
| cas_sel | input | 1 | CAS latency select: 0 gives 2, 1 gives 3; change only while idle |
| blen_code | input | 2 | Burst length code, sampled with the read |
| dq_valid | output | 1 | A data beat is driven this cycle |
| beat_idx | output | 3 | Index of the beat being driven; 0 when idle |
| pre_ok | output | 1 | Earliest cycle for a non-truncating precharge |

## Verification
The hardest situation to reach is a precharge that lands exactly at the edge of the allowed window. Issued in the `pre_ok` cycle, it must keep the last beat; issued one cycle earlier, it must drop only that beat. This has to hold for both latencies and all four burst lengths. The stimulus places each precharge at an offset from its read that is derived from the burst length. Two further cases are driven the same way: a read that interrupts a burst while an earlier read is still inside the latency pipeline, and a precharge that coincides with a read. A behavioural model keeps per-cycle schedules of expected beats and windows and is compared with the outputs on every clock.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  localparam int BLC_W  = 2;   // burst length code width
  localparam int BEAT_W = 3;   // beat index width, enough for 8 beats
  localparam int MIN_CL = 2;
  localparam int MAX_CL = 3;

  // index of the final beat for a burst length code (length - 1)
  function automatic logic [BEAT_W-1:0] last_beat(input logic [BLC_W-1:0] code);
    return BEAT_W'((1 << code) - 1);
  endfunction
endpackage

// File: rtl/sdr_cmd_delay.sv
module sdr_cmd_delay #(
  parameter int DEPTH = 2,
  parameter int PW    = 2,
  parameter int SEL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [PW-1:0]    in_pay,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tap_vld,
  output logic [PW-1:0]    tap_pay
);
  // stage k holds the command sampled k edges ago
  logic [DEPTH:1] sv;
  logic [PW-1:0]  sp [DEPTH:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sv <= '0;
    end else begin
      sv[1] <= in_vld;
      for (int k = 2; k <= DEPTH; k++) sv[k] <= sv[k-1];
    end
    sp[1] <= in_pay;
    for (int k = 2; k <= DEPTH; k++) sp[k] <= sp[k-1];
  end

  always_comb begin
    tap_vld = 1'b0;
    tap_pay = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      if (tap_sel == SEL_W'(k)) begin
        tap_vld = sv[k];
        tap_pay = sp[k];
      end
    end
  end
endmodule

// File: rtl/sdr_beat_engine.sv
module sdr_beat_engine import sdr_rd_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BLC_W-1:0]  start_blc,
  input  logic              cut,
  output logic              dq_valid,
  output logic [BEAT_W-1:0] beat_idx
);
  logic [BEAT_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_valid <= 1'b0;
      beat_idx <= '0;
      last_q   <= '0;
    end else if (start) begin
      // a new burst takes over even if an older one is running
      dq_valid <= 1'b1;
      beat_idx <= '0;
      last_q   <= last_beat(start_blc);
    end else if (cut || (dq_valid && beat_idx == last_q)) begin
      dq_valid <= 1'b0;
      beat_idx <= '0;
    end else if (dq_valid) begin
      beat_idx <= beat_idx + 1'b1;
    end
  end

  // R4
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> beat_idx == '0);

  // R2
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && beat_idx != '0) |-> ($past(dq_valid) && beat_idx == $past(beat_idx) + 1'b1));

  // R3
  beat_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> beat_idx <= last_q);
endmodule

// File: rtl/sdr_prewin_timer.sv
module sdr_prewin_timer import sdr_rd_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_take,
  input  logic [BLC_W-1:0] rd_blc,
  input  logic             pre_take,
  output logic             pre_ok
);
  logic              armed;
  logic [BEAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_ok <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
    end else begin
      pre_ok <= 1'b0;
      if (rd_take) begin
        // window opens burst-length cycles after the read
        if (rd_blc == '0) begin
          pre_ok <= 1'b1;
          armed  <= 1'b0;
        end else begin
          armed <= 1'b1;
          cnt   <= last_beat(rd_blc);
        end
      end else if (pre_take) begin
        armed <= 1'b0;
      end else if (armed) begin
        if (cnt == BEAT_W'(1)) begin
          pre_ok <= 1'b1;
          armed  <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R8
  ok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_ok && !rd_take) |=> !pre_ok);

  // R11
  ok_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    pre_take |=> !pre_ok);
endmodule

// File: rtl/sdr_rd_burst_ctrl.sv
module sdr_rd_burst_ctrl import sdr_rd_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_cmd,
  input  logic              pre_cmd,
  input  logic              pall_cmd,
  input  logic              cas_sel,
  input  logic [BLC_W-1:0]  blen_code,
  output logic              dq_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              pre_ok
);
  localparam int DLY   = MAX_CL - 1;
  localparam int SEL_W = $clog2(DLY + 1);

  logic             pre_take;
  logic [SEL_W-1:0] tap;
  logic             st_vld;
  logic [BLC_W-1:0] st_blc;
  logic             cut_vld;
  logic [0:0]       cut_pay;

  // a precharge coinciding with a read is dropped
  assign pre_take = (pre_cmd | pall_cmd) & ~rd_cmd;
  // output register adds the last cycle of latency
  assign tap = SEL_W'(MIN_CL - 1) + SEL_W'(cas_sel);

  sdr_cmd_delay #(.DEPTH(DLY), .PW(BLC_W), .SEL_W(SEL_W)) u_rd_dly (
    .clk(clk), .rst(rst), .in_vld(rd_cmd), .in_pay(blen_code),
    .tap_sel(tap), .tap_vld(st_vld), .tap_pay(st_blc)
  );

  // payload bit marks a bank-closing command
  sdr_cmd_delay #(.DEPTH(DLY), .PW(1), .SEL_W(SEL_W)) u_pre_dly (
    .clk(clk), .rst(rst), .in_vld(pre_take), .in_pay(1'b1),
    .tap_sel(tap), .tap_vld(cut_vld), .tap_pay(cut_pay)
  );

  sdr_beat_engine u_beats (
    .clk(clk), .rst(rst), .start(st_vld), .start_blc(st_blc),
    .cut(cut_vld & cut_pay[0]), .dq_valid(dq_valid), .beat_idx(beat_idx)
  );

  sdr_prewin_timer u_win (
    .clk(clk), .rst(rst), .rd_take(rd_cmd), .rd_blc(blen_code),
    .pre_take(pre_take), .pre_ok(pre_ok)
  );

  // R2
  lat2_chk: assert property (@(posedge clk) disable iff (rst)
    (!cas_sel && !$past(cas_sel) && !$past(cas_sel, 2) && $past(rd_cmd, 2))
      |-> (dq_valid && beat_idx == '0));

  // R2
  lat3_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_sel && $past(cas_sel) && $past(cas_sel, 2) && $past(cas_sel, 3) && $past(rd_cmd, 3))
      |-> (dq_valid && beat_idx == '0));

  // R5
  cut2_chk: assert property (@(posedge clk) disable iff (rst)
    (!cas_sel && !$past(cas_sel) && !$past(cas_sel, 2) && $past(pre_take, 2)) |-> !dq_valid);

  // R5
  cut3_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_sel && $past(cas_sel) && $past(cas_sel, 2) && $past(cas_sel, 3) && $past(pre_take, 3))
      |-> !dq_valid);
endmodule

// File: tb/sdr_rd_burst_ctrl_test.sv
module sdr_rd_burst_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd = 1'b0, pre = 1'b0, pall = 1'b0, cas = 1'b0;
  logic [1:0] blc = 2'd0;
  logic       dq_valid, pre_ok;
  logic [2:0] beat_idx;

  int    cyc = 0, checks = 0, errors = 0, beats = 0, oks = 0;
  bit    done = 1'b0;
  string req = "R1";

  bit ev[int];
  int ei[int];
  bit eo[int];

  always #5 clk = ~clk;

  sdr_rd_burst_ctrl uut (
    .clk(clk), .rst(rst), .rd_cmd(rd), .pre_cmd(pre), .pall_cmd(pall),
    .cas_sel(cas), .blen_code(blc), .dq_valid(dq_valid), .beat_idx(beat_idx),
    .pre_ok(pre_ok)
  );

  // behavioural schedule: expected output per absolute cycle
  always @(posedge clk) begin
    int c, cl, bl;
    c  = cyc;
    cl = 2 + int'(cas);
    bl = 1 << blc;
    if (rst) begin
      ev.delete(); ei.delete(); eo.delete();
    end else if (rd) begin
      for (int t = c + cl; t < c + cl + 24; t++) begin
        if (ev.exists(t)) ev.delete(t);
        if (ei.exists(t)) ei.delete(t);
      end
      for (int t = c + 1; t < c + 30; t++) if (eo.exists(t)) eo.delete(t);
      for (int k = 0; k < bl; k++) begin
        ev[c + cl + k] = 1'b1;
        ei[c + cl + k] = k;
      end
      eo[c + bl] = 1'b1;
    end else if (pre || pall) begin
      for (int t = c + cl; t < c + cl + 24; t++) begin
        if (ev.exists(t)) ev.delete(t);
        if (ei.exists(t)) ei.delete(t);
      end
      for (int t = c + 1; t < c + 30; t++) if (eo.exists(t)) eo.delete(t);
    end
    cyc = cyc + 1;
  end

  always @(negedge clk) begin
    bit xv, xo;
    int xi;
    if (cyc > 0 && !done) begin
      xv = ev.exists(cyc);
      xi = xv ? ei[cyc] : 0;
      xo = eo.exists(cyc);
      checks++;
      if (dq_valid !== xv || beat_idx !== xi[2:0] || pre_ok !== xo) begin
        errors++;
        $display("FAIL %s cycle %0d valid/idx/ok act %b/%0d/%b exp %b/%0d/%b",
                 req, cyc, dq_valid, beat_idx, pre_ok, xv, xi, xo);
      end
      if (dq_valid === 1'b1) beats++;
      if (pre_ok === 1'b1) oks++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", r, act, exp);
    end
  endtask

  task automatic issue(input bit r, input bit p, input bit pa);
    rd = r; pre = p; pall = pa;
    @(negedge clk); #1;
    rd = 1'b0; pre = 1'b0; pall = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  // read, then optional precharge pre_off cycles later; count delivered beats
  task automatic burst(input string r, input bit c3, input int code, input int pre_off,
                       input bit use_all, input int exp_beats, input int exp_oks);
    req = r;
    cas = c3; blc = 2'(code);
    idle(2);
    beats = 0; oks = 0;
    issue(1'b1, 1'b0, 1'b0);
    if (pre_off > 0) begin
      idle(pre_off - 1);
      issue(1'b0, !use_all, use_all);
    end
    idle(16);
    chk({r, " beats"}, beats, exp_beats);
    chk({r, " pre_ok pulses"}, oks, exp_oks);
  endtask

  initial begin
    idle(4);
    // R1 reset state
    chk("R1 valid", int'(dq_valid), 0);
    chk("R1 idx", int'(beat_idx), 0);
    chk("R1 pre_ok", int'(pre_ok), 0);
    rst = 1'b0;
    idle(3);

    // R2 R3 R4 R8 full bursts at both latencies and all lengths
    for (int c3 = 0; c3 < 2; c3++)
      for (int code = 0; code < 4; code++)
        burst("R2 R3 R8", c3[0], code, 0, 1'b0, 1 << code, 1);

    // R9 precharge in the window keeps all beats, one cycle earlier loses the last
    for (int c3 = 0; c3 < 2; c3++)
      for (int code = 0; code < 4; code++) begin
        burst("R9 in window", c3[0], code, 1 << code, 1'b0, 1 << code, 1);
        if (code > 0)
          burst("R9 early", c3[0], code, (1 << code) - 1, 1'b0, (1 << code) - 1, 0);
      end

    // R5 R11 truncation of a long burst, window cancelled
    burst("R5 cl2 pre+1", 1'b0, 3, 1, 1'b0, 1, 0);
    burst("R5 cl3 pre+3", 1'b1, 3, 3, 1'b0, 3, 0);
    burst("R11 cl3 pre+5", 1'b1, 3, 5, 1'b0, 5, 0);

    // R6 precharge-all truncates the same way
    burst("R6 cl2 pall+2", 1'b0, 3, 2, 1'b1, 2, 0);
    burst("R6 cl3 pall+1", 1'b1, 2, 1, 1'b1, 1, 0);

    // R7 precharge together with a read is ignored
    req = "R7"; cas = 1'b0; blc = 2'd2; idle(2); beats = 0; oks = 0;
    issue(1'b1, 1'b1, 1'b0);
    idle(16);
    chk("R7 beats", beats, 4);
    chk("R7 pre_ok pulses", oks, 1);

    // R10 read during a burst; second read while first is in the latency pipe
    req = "R10"; cas = 1'b1; blc = 2'd3; idle(2); beats = 0; oks = 0;
    issue(1'b1, 1'b0, 1'b0);
    idle(1);
    blc = 2'd2;
    issue(1'b1, 1'b0, 1'b0);
    idle(16);
    chk("R10 beats", beats, 2 + 4);
    chk("R10 R11 pre_ok pulses", oks, 1);

    // R10 restart at CL2 after three beats
    req = "R10 cl2"; cas = 1'b0; blc = 2'd3; idle(2); beats = 0;
    issue(1'b1, 1'b0, 1'b0);
    idle(2);
    blc = 2'd1;
    issue(1'b1, 1'b0, 1'b0);
    idle(16);
    chk("R10 cl2 beats", beats, 3 + 2);

    // R12 precharge with nothing in flight
    req = "R12"; idle(2); beats = 0; oks = 0;
    issue(1'b0, 1'b1, 1'b0);
    issue(1'b0, 1'b0, 1'b1);
    idle(8);
    chk("R12 beats", beats, 0);
    chk("R12 pre_ok pulses", oks, 0);

    // R1 reset in the middle of a burst
    req = "R1 mid"; cas = 1'b0; blc = 2'd3; idle(2);
    issue(1'b1, 1'b0, 1'b0);
    idle(3);
    rst = 1'b1;
    idle(2);
    chk("R1 mid valid", int'(dq_valid), 0);
    chk("R1 mid pre_ok", int'(pre_ok), 0);
    rst = 1'b0;
    idle(12);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule